// File: doc/BRIEF.md
# Serial Clock-and-Data Pattern Lane

This block is a single lane of a pattern generator. It takes a parallel pattern word and sends it out one bit at a time on a data line. Beside the data line it drives a clock line that it derives from the system clock. Three counters are nested inside one another: a clock divider that sets the line clock rate, a bit counter that steps through the word, and a pass counter that repeats the whole word. Each data bit changes when the divided clock falls. A receiver can therefore capture the data on the rising edge of the line clock, or on the falling edge when the polarity input inverts the clock.

When the lane is not enabled it is idle. It is also idle after the last pass. In both cases the clock and data lines sit at levels that software chooses, and completion is marked by a single-cycle pulse. Dropping the enable acts as a reset. The next enable always starts from the first bit. The configuration inputs must be held constant while the lane is enabled.

Top module: `pattern_lane`

## Requirements
- R1: While `enable` is low, including during reset, `line_clk` equals `idle_clk`, `line_data` equals `idle_data` and `done` is low. Dropping `enable` returns the lane to idle on the next clock.
- R2: The first system cycle after `enable` is sampled high is the first running cycle. In the running state the internal divided clock is low for `prediv`+1 cycles and then high for `prediv`+1 cycles, so its period is 2×(`prediv`+1) system cycles.
- R3: While running, `line_clk` equals the internal divided clock when `polarity` is 0. It equals the inverted internal divided clock when `polarity` is 1.
- R4: Bit 0 of `pattern` is sent first and each later index follows in turn. Every bit stays on `line_data` for one full divided-clock period. The bit index advances only when the internal divided clock goes from high to low.
- R5: A `last_bit` value of L sends bits 0 to L, which is L+1 bits per pass. After bit L the next bit sent is bit 0.
- R6: A `last_rep` value of R sends R+1 complete passes. The lane then stops running, after (L+1)(R+1)·2(`prediv`+1) running cycles.
- R7: After the last pass the lane stays stopped while `enable` remains high. In that state `line_clk` equals `idle_clk` and `line_data` equals `idle_data`.
- R8: `done` is high for exactly one system cycle: the first cycle of the stopped state.
- R9: If `enable` is dropped in the middle of a pattern and raised again, the lane restarts from bit 0, pass 0, with the divided clock low.
- R10: The full 64-bit word (`last_bit` = 63) is sent with every bit in its own position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; low forces idle |
| prediv | input | DIV_W | Half-period of the line clock minus one, in system cycles |
| pattern | input | DATA_W | Pattern word, bit 0 sent first |
| last_bit | input | LEN_W | Index of the last bit in a pass |
| polarity | input | 1 | Inverts the running line clock when high |
| last_rep | input | REP_W | Number of passes minus one |
| idle_clk | input | 1 | Clock line level when not running |
| idle_data | input | 1 | Data line level when not running |
| line_clk | output | 1 | Line clock |
| line_data | output | 1 | Serial data line |
| done | output | 1 | One-cycle completion pulse |

## Verification
If the divider count were wrong, the line clock would show a half-period of the wrong length. This is visible within the first 2×(`prediv`+1) cycles of a run. If the bit counter were wrong, a wrong data value, a repeated bit or a skipped bit would appear at the next falling edge of the divided clock. If the pass counter were wrong, the lane would stop early or late, and the timing of `done` and of the change to idle levels would move by whole passes. The scoreboard predicts every cycle of each run, so any such error is reported at the first cycle where it shows.

// File: rtl/pattern_lane_pkg.sv
package pattern_lane_pkg;

  typedef enum logic [1:0] {
    PL_IDLE = 2'd0,
    PL_RUN  = 2'd1,
    PL_STOP = 2'd2
  } pl_state_e;

  // Line level: running value while in PL_RUN, parked value otherwise
  function automatic logic pick_line(pl_state_e s, logic run_val, logic park_val);
    return (s == PL_RUN) ? run_val : park_val;
  endfunction

  // Running clock line after the optional inversion
  function automatic logic shape_clk(logic phase, logic invert);
    return phase ^ invert;
  endfunction

endpackage

// File: rtl/pattern_lane_div.sv
module pattern_lane_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [DIV_W-1:0] prediv,
  output logic             phase,
  output logic             half_ev,
  output logic             fall_ev
);

  logic [DIV_W-1:0] cnt;

  assign half_ev = run && (cnt == prediv);
  assign fall_ev = half_ev && phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (clear) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (run) begin
      if (half_ev) begin
        cnt   <= '0;
        phase <= ~phase;
      end else begin
        cnt   <= cnt + 1'b1;
      end
    end
  end

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= prediv)); // R2
  AST_DIV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0 && !phase)); // R1
  AST_DIV_HOLD_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_ev && !clear) |=> $stable(phase)); // R2

endmodule

// File: rtl/pattern_lane_seq.sv
module pattern_lane_seq #(
  parameter int LEN_W = 6,
  parameter int REP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [LEN_W-1:0] last_bit,
  input  logic [REP_W-1:0] last_rep,
  output logic [LEN_W-1:0] bit_idx,
  output logic             finish
);

  logic [REP_W-1:0] rep_idx;
  logic             bit_wrap;

  assign bit_wrap = step && (bit_idx == last_bit);
  assign finish   = bit_wrap && (rep_idx == last_rep);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx <= '0;
      rep_idx <= '0;
    end else if (clear) begin
      bit_idx <= '0;
      rep_idx <= '0;
    end else if (step) begin
      if (bit_wrap) begin
        bit_idx <= '0;
        rep_idx <= (rep_idx == last_rep) ? '0 : rep_idx + 1'b1;
      end else begin
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  AST_BIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_idx <= last_bit); // R5
  AST_REP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rep_idx <= last_rep); // R6
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clear) |=> $stable(bit_idx)); // R4

endmodule

// File: rtl/pattern_lane.sv
module pattern_lane #(
  parameter int DATA_W = 64,
  parameter int DIV_W  = 16,
  parameter int REP_W  = 16,
  localparam int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DIV_W-1:0]  prediv,
  input  logic [DATA_W-1:0] pattern,
  input  logic [LEN_W-1:0]  last_bit,
  input  logic              polarity,
  input  logic [REP_W-1:0]  last_rep,
  input  logic              idle_clk,
  input  logic              idle_data,
  output logic              line_clk,
  output logic              line_data,
  output logic              done
);
  import pattern_lane_pkg::*;

  pl_state_e        st, st_nx;
  logic             phase, half_ev, fall_ev, finish;
  logic [LEN_W-1:0] bit_idx;
  logic             clr_cnt, run_cnt;

  assign clr_cnt = (st == PL_IDLE);
  assign run_cnt = (st == PL_RUN);

  pattern_lane_div #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clr_cnt),
    .run     (run_cnt),
    .prediv  (prediv),
    .phase   (phase),
    .half_ev (half_ev),
    .fall_ev (fall_ev)
  );

  pattern_lane_seq #(.LEN_W(LEN_W), .REP_W(REP_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clr_cnt),
    .step     (fall_ev),
    .last_bit (last_bit),
    .last_rep (last_rep),
    .bit_idx  (bit_idx),
    .finish   (finish)
  );

  always_comb begin
    st_nx = st;
    if (!enable) begin
      st_nx = PL_IDLE;
    end else begin
      unique case (st)
        PL_IDLE: st_nx = PL_RUN;
        PL_RUN:  st_nx = finish ? PL_STOP : PL_RUN;
        PL_STOP: st_nx = PL_STOP;
        default: st_nx = PL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= PL_IDLE;
      done <= 1'b0;
    end else begin
      st   <= st_nx;
      done <= enable && (st == PL_RUN) && finish;
    end
  end

  assign line_clk  = pick_line(st, shape_clk(phase, polarity), idle_clk);
  assign line_data = pick_line(st, pattern[bit_idx], idle_data);

  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (st == PL_IDLE)); // R1
  AST_START_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PL_IDLE && enable) |=> (st == PL_RUN)); // R9
  AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PL_STOP && enable) |=> (st == PL_STOP)); // R7
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (st == PL_STOP)); // R8
  AST_STEP_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev |=> !phase); // R4

endmodule

// File: tb/pattern_lane_tb.sv
module pattern_lane_tb;
  localparam int DATA_W = 64;
  localparam int DIV_W  = 16;
  localparam int REP_W  = 16;
  localparam int LEN_W  = $clog2(DATA_W);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              enable = 1'b0;
  logic [DIV_W-1:0]  prediv = '0;
  logic [DATA_W-1:0] pattern = '0;
  logic [LEN_W-1:0]  last_bit = '0;
  logic              polarity = 1'b0;
  logic [REP_W-1:0]  last_rep = '0;
  logic              idle_clk = 1'b1;
  logic              idle_data = 1'b0;
  logic              line_clk, line_data, done;

  always #10 clk = ~clk; // 50 MHz

  pattern_lane #(.DATA_W(DATA_W), .DIV_W(DIV_W), .REP_W(REP_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .prediv(prediv),
    .pattern(pattern), .last_bit(last_bit), .polarity(polarity),
    .last_rep(last_rep), .idle_clk(idle_clk), .idle_data(idle_data),
    .line_clk(line_clk), .line_data(line_data), .done(done)
  );

  typedef struct {
    logic  c;
    logic  d;
    logic  dn;
    string tag;
  } exp_t;

  exp_t q[$];
  int   vecs = 0;
  int   fails = 0;
  bit   finished = 1'b0;

  // Monitor: one expected item per system cycle, compared at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        vecs++;
        if (line_clk !== e.c || line_data !== e.d || done !== e.dn) begin
          fails++;
          $display("FAIL %s: clk=%b data=%b done=%b, expected clk=%b data=%b done=%b",
                   e.tag, line_clk, line_data, done, e.c, e.d, e.dn);
        end
      end
    end
  end

  function automatic exp_t mk(logic c, logic d, logic dn, string tag);
    exp_t e;
    e.c = c; e.d = d; e.dn = dn; e.tag = tag;
    return e;
  endfunction

  // Running-cycle model restated from the requirements
  function automatic exp_t run_item(int j, string tag);
    int half, ph, b;
    half = int'(prediv) + 1;
    ph   = (j / half) % 2;
    b    = (j / (2 * half)) % (int'(last_bit) + 1);
    return mk(ph[0] ^ polarity, pattern[b], 1'b0, tag);
  endfunction

  function automatic int run_len();
    return (int'(last_bit) + 1) * (int'(last_rep) + 1) * 2 * (int'(prediv) + 1);
  endfunction

  task automatic push_idle(int n);
    for (int i = 0; i < n; i++) q.push_back(mk(idle_clk, idle_data, 1'b0, "R1"));
  endtask

  task automatic push_run(int j0, int j1, string tag);
    for (int j = j0; j < j1; j++) q.push_back(run_item(j, tag));
  endtask

  task automatic push_stop(int n);
    q.push_back(mk(idle_clk, idle_data, 1'b1, "R8"));
    for (int i = 1; i < n; i++) q.push_back(mk(idle_clk, idle_data, 1'b0, "R7"));
  endtask

  task automatic start(input logic [DIV_W-1:0] p, input logic [LEN_W-1:0] l,
                       input logic [REP_W-1:0] r, input logic pol,
                       input logic [DATA_W-1:0] pat, input logic ic, input logic id);
    wait (q.size() == 0);
    @(posedge clk); #2;
    prediv = p; last_bit = l; last_rep = r; polarity = pol;
    pattern = pat; idle_clk = ic; idle_data = id;
    enable = 1'b1;
    push_idle(1); // state still idle for this sample
  endtask

  task automatic stop(exp_t carry, int n_idle);
    wait (q.size() == 0);
    @(posedge clk); #2;
    enable = 1'b0;
    q.push_back(carry);
    push_idle(n_idle);
  endtask

  initial begin
    // R1: reset state, then idle after reset release
    @(posedge clk); #2;
    push_idle(3);
    wait (q.size() == 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    push_idle(3);

    // R2 R4 R5: fastest divider, four bits 1,1,0,1, single pass, parked levels 0/1
    start(16'd0, 6'd3, 16'd0, 1'b0, 64'h0B, 1'b0, 1'b1);
    push_run(0, run_len(), "R4");
    push_stop(4);
    stop(mk(idle_clk, idle_data, 1'b0, "R7"), 3);

    // R3 R6: divide by 6, five bits, two passes, inverted clock
    start(16'd2, 6'd4, 16'd1, 1'b1, 64'h16, 1'b1, 1'b0);
    push_run(0, run_len() / 2, "R3");
    push_run(run_len() / 2, run_len(), "R6");
    push_stop(5);
    stop(mk(idle_clk, idle_data, 1'b0, "R7"), 3);

    // R10: whole 64-bit word
    start(16'd1, 6'd63, 16'd0, 1'b0, 64'hF0E1_D2C3_B4A5_9687, 1'b0, 1'b0);
    push_run(0, run_len(), "R10");
    push_stop(3);
    stop(mk(idle_clk, idle_data, 1'b0, "R7"), 2);

    // R9: drop enable mid-pattern, then restart from bit 0
    start(16'd1, 6'd7, 16'd2, 1'b0, 64'hA5, 1'b1, 1'b1);
    push_run(0, 10, "R9");
    stop(run_item(10, "R9"), 4);
    start(16'd1, 6'd7, 16'd2, 1'b0, 64'hA5, 1'b1, 1'b1);
    push_run(0, run_len(), "R9");
    push_stop(3);
    stop(mk(idle_clk, idle_data, 1'b0, "R7"), 3);

    wait (q.size() == 0);
    @(posedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

endmodule